// File: doc/BRIEF.md
# PRNG Entropy Reseed Controller

This block decides when an internal pseudo-random generator, built from a number of 32-bit LFSR chunks (five by default), receives a new seed and where that seed comes from. After reset the block sits in a default mode in which the generator is never reseeded and command processing is allowed at once. Configuration selects one of two other sources. The first is an external entropy source reached through a request/acknowledge handshake, which delivers one 32-bit word per acknowledge. The second is software, which writes the seed words one by one. The chosen source takes effect only when an entropy-ready input is raised. Once the block has left the default mode it never returns to it until reset.

Each seed word that is accepted comes out on a load strobe with its chunk index and data, for the LFSR logic next to this block. While an external request is outstanding, a prescaled wait timer runs. If the timer expires, the block goes to a sticky fault state that only an error-processed pulse clears. A counter of completed hash operations is compared against a refresh threshold, and reaching the threshold requests a reseed. Software can also clear that counter or ask for a reseed by hand. The ready output tells the surrounding controller when commands may be processed.

Top module: `prng_reseed_ctrl`

## Requirements
- R1: After reset, ready_o is 1 and ent_req_o, err_o, seed_load_o and hash_cnt_o are all 0. The block starts in the default mode.
- R2: mode_i is encoded 0 = default, 1 = external entropy, 2 = software seed, and 3 is treated like 0. A mode of 1 or 2 takes effect only in a cycle where entropy_ready_i is 1. After leaving the default mode the block never returns to it, whatever mode_i later holds.
- R3: On entry into external mode, ent_req_o is 1 and ready_o is 0 in the following cycle. Each cycle with ent_ack_i high during a request gives seed_load_o = 1 in that same cycle, with seed_idx_o equal to 0, 1, 2 and so on in turn and seed_word_o equal to ent_data_i. After the last chunk's acknowledge, ent_req_o is 0 and ready_o is 1 in the next cycle.
- R4: In software mode, ready_o is 0 until every chunk has been written once, in ascending index order. A write (seed_we_i) is accepted, with seed_load_o = 1 and seed_word_o = seed_data_i in the same cycle, only when seed_idx_i equals the next expected index. A write to any other index gives no load. ready_o rises in the cycle after the last chunk is written.
- R5: Once the software seed sequence has completed, seed writes give no load, even if mode_i is changed and changed back.
- R6: The wait timer counts ticks only while a request is outstanding. A tick occurs each time the cycle count reaches prescale_i, so every prescale_i+1 cycles. With a nonzero wait_limit_i = L, err_o rises in the request's cycle L*(prescale_i+1)+1, counting the first request cycle as 0, unless every chunk has been acknowledged by then. In the fault state ent_req_o and ready_o are 0.
- R7: With wait_limit_i = 0 a request never times out.
- R8: err_o stays at 1 until err_processed_i is pulsed, and no request is issued while it is 1, even on a manual reseed. After err_processed_i, err_o is 0 and ready_o is 1 in the next cycle.
- R9: hash_cnt_o increases by one in the cycle after each hash_done_i pulse. A hash_cnt_clr_i pulse makes it 0 in the next cycle, taking priority over a simultaneous hash_done_i.
- R10: When hash_cnt_o >= threshold_i and threshold_i is nonzero, the counter is 0 in the next cycle. In external mode with the block ready, a request is also raised in that same next cycle. A threshold of 0 never triggers this.
- R11: In external mode with the block ready, a manual_reseed_i pulse raises ent_req_o in the next cycle. A reseed request that arrives while a request is already outstanding is merged into it: the usual number of acknowledges ends the request and no second request follows.
- R12: When mode_i is 2 after seeding, manual and threshold reseed requests raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Entropy source select: 0 default, 1 external, 2 software |
| entropy_ready_i | input | 1 | Allows a non-default mode to take effect |
| seed_we_i | input | 1 | Software seed word write strobe |
| seed_idx_i | input | 3 | Index of the software seed word |
| seed_data_i | input | 32 | Software seed word |
| ent_req_o | output | 1 | External entropy request, held until served or faulted |
| ent_ack_i | input | 1 | External entropy word valid |
| ent_data_i | input | 32 | External entropy word |
| prescale_i | input | 10 | Wait timer prescaler value |
| wait_limit_i | input | 16 | Wait timer limit in ticks, 0 waits forever |
| threshold_i | input | 10 | Hash count refresh threshold, 0 disables |
| hash_done_i | input | 1 | One pulse per completed hash operation |
| hash_cnt_clr_i | input | 1 | Clears the hash counter |
| manual_reseed_i | input | 1 | Software reseed request |
| err_processed_i | input | 1 | Leaves the fault state |
| seed_load_o | output | 1 | Seed chunk load strobe |
| seed_idx_o | output | 3 | Chunk index being loaded |
| seed_word_o | output | 32 | Chunk data being loaded |
| ready_o | output | 1 | Command processing permitted |
| err_o | output | 1 | Sticky request-timeout fault |
| hash_cnt_o | output | 10 | Completed hash operation count |

## Verification
The seed load strobe, index and word depend only on the inputs and the current state, so the bench changes the acknowledge or write inputs just after a falling edge and checks those outputs a moment later, before the next rising edge. Request, ready and fault outputs, and the hash count, change one rising edge after the stimulus. A threshold refresh shows up one edge after the count reaches the threshold, and a timeout shows up at cycle L*(prescale_i+1)+1 of the request. All inputs are driven and all outputs sampled on falling edges. The bench counts rising edges from the first sample that shows the request, checks err_o low one cycle before the due cycle and high in it, and so pins the exact cycle.

// File: rtl/prng_reseed_pkg.sv
package prng_reseed_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SWSEED = 3'd1,
      ST_FETCH  = 3'd2,
      ST_RUN    = 3'd3,
      ST_FAULT  = 3'd4
   } rs_state_e;

   localparam logic [1:0] MODE_DEFAULT = 2'd0;
   localparam logic [1:0] MODE_EXT     = 2'd1;
   localparam logic [1:0] MODE_SW      = 2'd2;

endpackage

// File: rtl/reseed_wait_timer.sv
module reseed_wait_timer #(
   parameter int unsigned PreW      = 10,
   parameter int unsigned WaitW     = 16,
   parameter bit          EnTimeout = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             active_i,
   input  logic [PreW-1:0]  prescale_i,
   input  logic [WaitW-1:0] limit_i,
   output logic             expired_o
);

   if (PreW < 1 || WaitW < 1) begin : g_bad_width
      $error("reseed_wait_timer: widths must be at least 1");
   end

   if (EnTimeout) begin : g_timer
      logic [PreW-1:0]  cyc_q;
      logic [WaitW-1:0] tick_q;
      logic             tick;

      assign tick = active_i && (cyc_q == prescale_i);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cyc_q  <= '0;
            tick_q <= '0;
         end else if (!active_i) begin
            cyc_q  <= '0;
            tick_q <= '0;
         end else begin
            cyc_q <= tick ? '0 : cyc_q + 1'b1;
            if (tick && !(&tick_q)) begin
               tick_q <= tick_q + 1'b1;
            end
         end
      end

      assign expired_o = active_i && (limit_i != '0) && (tick_q >= limit_i);
   end else begin : g_no_timer
      logic unused_timer_in;
      assign unused_timer_in = ^{clk_i, rst_ni, active_i, prescale_i, limit_i};
      assign expired_o = 1'b0;
   end

endmodule

// File: rtl/reseed_hash_counter.sv
module reseed_hash_counter #(
   parameter int unsigned CntW = 10
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            done_i,
   input  logic            clr_i,
   input  logic [CntW-1:0] threshold_i,
   output logic [CntW-1:0] cnt_o,
   output logic            refresh_o
);

   if (CntW < 2) begin : g_bad_width
      $error("reseed_hash_counter: CntW must be at least 2");
   end

   logic [CntW-1:0] cnt_q, cnt_d;

   assign refresh_o = (threshold_i != '0) && (cnt_q >= threshold_i);

   always_comb begin
      if (clr_i) begin
         cnt_d = '0;
      end else if (refresh_o) begin
         cnt_d = done_i ? CntW'(1) : '0;
      end else if (done_i && !(&cnt_q)) begin
         cnt_d = cnt_q + 1'b1;
      end else begin
         cnt_d = cnt_q;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/reseed_chunk_seq.sv
module reseed_chunk_seq #(
   parameter int unsigned NumChunks = 5,
   localparam int unsigned IdxW     = (NumChunks > 1) ? $clog2(NumChunks) : 1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            restart_i,
   input  logic            adv_i,
   output logic [IdxW-1:0] idx_o,
   output logic            last_o
);

   localparam logic [IdxW-1:0] LastIdx = IdxW'(NumChunks - 1);

   logic [IdxW-1:0] idx_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idx_q <= '0;
      end else if (restart_i) begin
         idx_q <= '0;
      end else if (adv_i) begin
         idx_q <= (idx_q == LastIdx) ? '0 : idx_q + 1'b1;
      end
   end

   assign idx_o  = idx_q;
   assign last_o = (idx_q == LastIdx);

endmodule

// File: rtl/prng_reseed_ctrl.sv
module prng_reseed_ctrl
   import prng_reseed_pkg::*;
#(
   parameter int unsigned NumChunks = 5,
   parameter int unsigned WordW     = 32,
   parameter int unsigned PreW      = 10,
   parameter int unsigned WaitW     = 16,
   parameter int unsigned HashCntW  = 10,
   parameter bit          EnTimeout = 1'b1,
   localparam int unsigned IdxW     = (NumChunks > 1) ? $clog2(NumChunks) : 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [1:0]          mode_i,
   input  logic                entropy_ready_i,
   input  logic                seed_we_i,
   input  logic [IdxW-1:0]     seed_idx_i,
   input  logic [WordW-1:0]    seed_data_i,
   output logic                ent_req_o,
   input  logic                ent_ack_i,
   input  logic [WordW-1:0]    ent_data_i,
   input  logic [PreW-1:0]     prescale_i,
   input  logic [WaitW-1:0]    wait_limit_i,
   input  logic [HashCntW-1:0] threshold_i,
   input  logic                hash_done_i,
   input  logic                hash_cnt_clr_i,
   input  logic                manual_reseed_i,
   input  logic                err_processed_i,
   output logic                seed_load_o,
   output logic [IdxW-1:0]     seed_idx_o,
   output logic [WordW-1:0]    seed_word_o,
   output logic                ready_o,
   output logic                err_o,
   output logic [HashCntW-1:0] hash_cnt_o
);

   if (NumChunks < 2 || NumChunks > 64) begin : g_bad_chunks
      $error("prng_reseed_ctrl: NumChunks must lie in 2..64");
   end
   if (WordW < 1) begin : g_bad_word
      $error("prng_reseed_ctrl: WordW must be at least 1");
   end

   rs_state_e       state_q, state_d;
   logic [IdxW-1:0] chunk_idx;
   logic            chunk_last;
   logic            sw_hit, ext_hit;
   logic            expired;
   logic            refresh;
   logic            reseed_want;
   logic            seeding;

   assign seeding = (state_q == ST_SWSEED) || (state_q == ST_FETCH);
   assign sw_hit  = (state_q == ST_SWSEED) && seed_we_i && (seed_idx_i == chunk_idx);
   assign ext_hit = (state_q == ST_FETCH) && ent_ack_i;

   reseed_chunk_seq #(
      .NumChunks (NumChunks)
   ) u_chunk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (!seeding),
      .adv_i     (sw_hit || ext_hit),
      .idx_o     (chunk_idx),
      .last_o    (chunk_last)
   );

   reseed_wait_timer #(
      .PreW      (PreW),
      .WaitW     (WaitW),
      .EnTimeout (EnTimeout)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .active_i   (state_q == ST_FETCH),
      .prescale_i (prescale_i),
      .limit_i    (wait_limit_i),
      .expired_o  (expired)
   );

   reseed_hash_counter #(
      .CntW (HashCntW)
   ) u_hash (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .done_i      (hash_done_i),
      .clr_i       (hash_cnt_clr_i),
      .threshold_i (threshold_i),
      .cnt_o       (hash_cnt_o),
      .refresh_o   (refresh)
   );

   assign reseed_want = manual_reseed_i || refresh;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (entropy_ready_i && mode_i == MODE_EXT) begin
               state_d = ST_FETCH;
            end else if (entropy_ready_i && mode_i == MODE_SW) begin
               state_d = ST_SWSEED;
            end
         end
         ST_SWSEED: begin
            if (sw_hit && chunk_last) state_d = ST_RUN;
         end
         ST_FETCH: begin
            if (ext_hit && chunk_last) state_d = ST_RUN;
            else if (expired)          state_d = ST_FAULT;
         end
         ST_RUN: begin
            if (reseed_want && mode_i == MODE_EXT) state_d = ST_FETCH;
         end
         ST_FAULT: begin
            if (err_processed_i) state_d = ST_RUN;
         end
         default: state_d = ST_FAULT;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign seed_load_o = sw_hit || ext_hit;
   assign seed_idx_o  = chunk_idx;
   assign seed_word_o = ext_hit ? ent_data_i : seed_data_i;
   assign ent_req_o   = (state_q == ST_FETCH);
   assign ready_o     = (state_q == ST_IDLE) || (state_q == ST_RUN);
   assign err_o       = (state_q == ST_FAULT);

endmodule

// File: rtl/prng_reseed_ctrl_sva.sv
module prng_reseed_ctrl_sva
   import prng_reseed_pkg::*;
#(
   parameter int unsigned HashCntW = 10
) (
   input logic                clk_i,
   input logic                rst_ni,
   input rs_state_e           state_q,
   input logic                ent_req_o,
   input logic                ready_o,
   input logic                err_o,
   input logic                err_processed_i,
   input logic                seed_load_o,
   input logic                hash_cnt_clr_i,
   input logic [HashCntW-1:0] hash_cnt_o
);

   AST_NO_IDLE_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE) |=> (state_q != ST_IDLE)); // R2

   AST_NOT_READY_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ent_req_o |-> !ready_o); // R3

   AST_LOAD_ONLY_SEEDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seed_load_o |-> !ready_o); // R5

   AST_FAULT_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> $past(ent_req_o)); // R6

   AST_FAULT_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> !ent_req_o); // R8

   AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_o && !err_processed_i) |=> err_o); // R8

   AST_HASH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hash_cnt_clr_i |=> (hash_cnt_o == '0)); // R9

endmodule

bind prng_reseed_ctrl prng_reseed_ctrl_sva #(
   .HashCntW (HashCntW)
) u_sva (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .state_q         (state_q),
   .ent_req_o       (ent_req_o),
   .ready_o         (ready_o),
   .err_o           (err_o),
   .err_processed_i (err_processed_i),
   .seed_load_o     (seed_load_o),
   .hash_cnt_clr_i  (hash_cnt_clr_i),
   .hash_cnt_o      (hash_cnt_o)
);

// File: tb/prng_reseed_ctrl_bench.sv
module prng_reseed_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = '0;
   logic        ent_rdy = 1'b0;
   logic        seed_we = 1'b0;
   logic [2:0]  seed_idx = '0;
   logic [31:0] seed_data = '0;
   logic        ent_req;
   logic        ent_ack = 1'b0;
   logic [31:0] ent_data = '0;
   logic [9:0]  prescale = '0;
   logic [15:0] wait_limit = '0;
   logic [9:0]  threshold = '0;
   logic        hash_done = 1'b0;
   logic        hash_clr = 1'b0;
   logic        manual = 1'b0;
   logic        err_proc = 1'b0;
   logic        seed_load;
   logic [2:0]  seed_idx_out;
   logic [31:0] seed_word;
   logic        ready;
   logic        err;
   logic [9:0]  hash_cnt;

   int checks = 0;
   int failures = 0;
   bit done_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prng_reseed_ctrl u_prng_reseed_ctrl (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .mode_i          (mode),
      .entropy_ready_i (ent_rdy),
      .seed_we_i       (seed_we),
      .seed_idx_i      (seed_idx),
      .seed_data_i     (seed_data),
      .ent_req_o       (ent_req),
      .ent_ack_i       (ent_ack),
      .ent_data_i      (ent_data),
      .prescale_i      (prescale),
      .wait_limit_i    (wait_limit),
      .threshold_i     (threshold),
      .hash_done_i     (hash_done),
      .hash_cnt_clr_i  (hash_clr),
      .manual_reseed_i (manual),
      .err_processed_i (err_proc),
      .seed_load_o     (seed_load),
      .seed_idx_o      (seed_idx_out),
      .seed_word_o     (seed_word),
      .ready_o         (ready),
      .err_o           (err),
      .hash_cnt_o      (hash_cnt)
   );

   task automatic step(int n = 1);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; mode = '0; ent_rdy = 1'b0; seed_we = 1'b0; seed_idx = '0;
      seed_data = '0; ent_ack = 1'b0; ent_data = '0; prescale = 10'd3;
      wait_limit = '0; threshold = '0; hash_done = 1'b0; hash_clr = 1'b0;
      manual = 1'b0; err_proc = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   // Serves an outstanding request with NCH acknowledges.
   task automatic serve_ext(logic [31:0] base, string tag);
      for (int i = 0; i < NCH; i++) begin
         ent_ack = 1'b1; ent_data = base + 32'(i);
         #1;
         chk({tag, " R3 load"}, 32'(seed_load), 32'd1);
         chk({tag, " R3 index"}, 32'(seed_idx_out), 32'(i));
         chk({tag, " R3 word"}, seed_word, base + 32'(i));
         step(1);
      end
      ent_ack = 1'b0;
   endtask

   task automatic enter_ext_and_seed();
      mode = 2'd1; ent_rdy = 1'b1;
      step(1);
      chk("R3 request raised", 32'(ent_req), 32'd1);
      chk("R3 not ready during request", 32'(ready), 32'd0);
      serve_ext(32'hA000_0000, "init");
      chk("R3 request dropped", 32'(ent_req), 32'd0);
      chk("R3 ready after seed", 32'(ready), 32'd1);
   endtask

   task automatic t_reset_idle();
      do_reset();
      chk("R1 ready", 32'(ready), 32'd1);
      chk("R1 req", 32'(ent_req), 32'd0);
      chk("R1 err", 32'(err), 32'd0);
      chk("R1 load", 32'(seed_load), 32'd0);
      chk("R1 hash count", 32'(hash_cnt), 32'd0);
      mode = 2'd1;
      manual = 1'b1;
      step(3);
      manual = 1'b0;
      chk("R2 no entry without entropy ready", 32'(ent_req), 32'd0);
      mode = 2'd3; ent_rdy = 1'b1;
      step(2);
      chk("R2 mode 3 stays default req", 32'(ent_req), 32'd0);
      chk("R2 mode 3 stays default ready", 32'(ready), 32'd1);
   endtask

   task automatic t_ext_lock_merge();
      do_reset();
      enter_ext_and_seed();
      ent_rdy = 1'b0; mode = 2'd0;
      step(2);
      chk("R2 still ready with mode 0", 32'(ready), 32'd1);
      mode = 2'd1; manual = 1'b1;
      step(1);
      manual = 1'b0;
      chk("R2 R11 manual reseed requests (no idle return)", 32'(ent_req), 32'd1);
      step(2);
      manual = 1'b1;
      step(1);
      manual = 1'b0;
      serve_ext(32'hB000_0000, "merge");
      chk("R11 merged request ends after one set", 32'(ent_req), 32'd0);
      step(3);
      chk("R11 no second request", 32'(ent_req), 32'd0);
      chk("R11 ready after merged request", 32'(ready), 32'd1);
   endtask

   task automatic t_timeout();
      do_reset();
      prescale = 10'd3; wait_limit = 16'd2;
      mode = 2'd1; ent_rdy = 1'b1;
      step(1);
      chk("R6 request cycle 0", 32'(ent_req), 32'd1);
      step(8);
      chk("R6 no fault at cycle 8", 32'(err), 32'd0);
      step(1);
      chk("R6 fault at cycle 9", 32'(err), 32'd1);
      chk("R6 req dropped in fault", 32'(ent_req), 32'd0);
      chk("R6 not ready in fault", 32'(ready), 32'd0);
      manual = 1'b1;
      step(2);
      manual = 1'b0;
      chk("R8 fault sticky", 32'(err), 32'd1);
      chk("R8 no request in fault", 32'(ent_req), 32'd0);
      err_proc = 1'b1;
      step(1);
      err_proc = 1'b0;
      chk("R8 fault cleared", 32'(err), 32'd0);
      chk("R8 ready after clear", 32'(ready), 32'd1);
   endtask

   task automatic t_no_timeout();
      do_reset();
      prescale = 10'd0; wait_limit = 16'd0;
      mode = 2'd1; ent_rdy = 1'b1;
      step(100);
      chk("R7 no fault with limit 0", 32'(err), 32'd0);
      chk("R7 request still held", 32'(ent_req), 32'd1);
   endtask

   task automatic t_sw_seed();
      do_reset();
      mode = 2'd2; ent_rdy = 1'b1;
      step(1);
      chk("R4 not ready in sw mode", 32'(ready), 32'd0);
      chk("R4 no request in sw mode", 32'(ent_req), 32'd0);
      seed_we = 1'b1; seed_idx = 3'd1; seed_data = 32'h1111;
      #1;
      chk("R4 out of order write ignored", 32'(seed_load), 32'd0);
      step(1);
      for (int i = 0; i < NCH; i++) begin
         seed_idx = 3'(i); seed_data = 32'hC0DE_0000 + 32'(i);
         #1;
         chk("R4 ordered write loads", 32'(seed_load), 32'd1);
         chk("R4 index", 32'(seed_idx_out), 32'(i));
         chk("R4 word", seed_word, 32'hC0DE_0000 + 32'(i));
         if (i < NCH - 1) begin
            step(1);
            chk("R4 not ready mid-sequence", 32'(ready), 32'd0);
         end else begin
            step(1);
         end
      end
      seed_we = 1'b0;
      chk("R4 ready after last word", 32'(ready), 32'd1);
      mode = 2'd1; step(1); mode = 2'd2;
      seed_we = 1'b1; seed_idx = 3'd0;
      #1;
      chk("R5 later seed write ignored", 32'(seed_load), 32'd0);
      step(1);
      seed_we = 1'b0;
      manual = 1'b1;
      step(1);
      manual = 1'b0;
      chk("R12 manual reseed ignored in sw mode", 32'(ent_req), 32'd0);
      threshold = 10'd1; hash_done = 1'b1;
      step(1);
      hash_done = 1'b0;
      step(1);
      chk("R12 threshold refresh clears count", 32'(hash_cnt), 32'd0);
      chk("R12 threshold refresh no request in sw mode", 32'(ent_req), 32'd0);
   endtask

   task automatic t_hash();
      do_reset();
      enter_ext_and_seed();
      threshold = 10'd0;
      for (int i = 1; i <= 4; i++) begin
         hash_done = 1'b1;
         step(1);
         chk("R9 count increments", 32'(hash_cnt), 32'(i));
      end
      hash_done = 1'b0;
      step(2);
      chk("R10 threshold 0 no refresh", 32'(hash_cnt), 32'd4);
      chk("R10 threshold 0 no request", 32'(ent_req), 32'd0);
      hash_clr = 1'b1; hash_done = 1'b1;
      step(1);
      hash_clr = 1'b0; hash_done = 1'b0;
      chk("R9 clear has priority", 32'(hash_cnt), 32'd0);
      threshold = 10'd3;
      hash_done = 1'b1;
      step(2);
      chk("R10 below threshold no request", 32'(ent_req), 32'd0);
      step(1);
      hash_done = 1'b0;
      chk("R10 count reaches threshold", 32'(hash_cnt), 32'd3);
      chk("R10 no request yet", 32'(ent_req), 32'd0);
      step(1);
      chk("R10 count cleared", 32'(hash_cnt), 32'd0);
      chk("R10 refresh request", 32'(ent_req), 32'd1);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      t_reset_idle();
      t_ext_lock_merge();
      t_timeout();
      t_no_timeout();
      t_sw_seed();
      t_hash();
      finish_run();
   end

endmodule